// File: doc/BRIEF.md
# Multi-Rate Systolic FIR Array

This block is a finite impulse response filter made of two networks. Each network holds eight multiply-accumulate stages. The system clock runs at 1, 2, 4 or 8 times the sample rate. Each stage reuses its one multiplier once per clock inside a sample period, so a higher clock ratio gives more taps per stage. A network therefore provides 8 × ratio taps. In every clock a stage multiplies one delayed sample by one coefficient. It adds the product either to its own running sum or, in the first clock of the period, to the partial sum that the stage before it handed on at the end of the previous period. Partial sums move one stage along the chain per sample period.

In dual mode the two networks filter two independent input channels, for example the in-phase and quadrature outputs of a mixer. In single mode network B continues the chain of network A on the same input, which gives one filter twice as long. A rising edge on the enable input marks the first sample. A clear input empties the accumulators and the sample history. Coefficients are written through a simple write port into an internal store with one bank per network.

Top module: `msfirArray`

## Requirements
- R1: After reset, `resultA`, `resultB` and `outValid` are all zero.
- R2: In dual mode (`dualSel`=1) with ratio R, and n counted from 0 at the enable edge, the result for sample n is as follows. On `resultA` it is the sum over k < 8R of bankA[k]·dataA[n−k]. On `resultB` it is the same sum using bankB and `dataB`. Samples taken before the enable edge count as zero.
- R3: In single mode (`dualSel`=0) each result is the sum over k < 16R of c[k]·dataA[n−k]. Here c[k] is bank 0 address k for k < 8R, and bank 1 address k−8R otherwise. The same value appears on both `resultA` and `resultB`.
- R4: `ratioSel` values 0, 1, 2 and 3 select R = 1, 2, 4 and 8. The data inputs are sampled on the clock edge that first sees `fen` high, and then on every R-th edge while `fen` stays high.
- R5: `outValid` is a one-cycle pulse, at most one per sample period. Let L be 7 in dual mode and 15 in single mode. The first pulse is registered (L+1)·R edges after the edge that samples the enable rise, and it carries the result for sample 0. Results then follow in sample order, one per period. When `fen` falls after N samples, exactly N−L results have appeared.
- R6: Accumulation is 32-bit two's complement with wrap-around. The samples and coefficients are 16-bit signed.
- R7: `ratioSel` and `dualSel` are captured only on edges where `fen` is low and the filter is idle. Changes to them during a run have no effect on the results.
- R8: A `clr` pulse zeroes every accumulator, every hand-on register and the whole sample history. Both outputs read zero after the clearing edge, and a following run behaves as if it had no earlier history.
- R9: When `coefWe` is high, a clock edge writes `coefData` into bank `coefNet` at tap address `coefAddr`. The coefficient store is not affected by `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of accumulators and sample history |
| fen | input | 1 | Filter enable; its rising edge marks the first sample |
| ratioSel | input | 2 | Clock-to-sample ratio select (log2 of R) |
| dualSel | input | 1 | 1 = two independent filters, 0 = one combined filter |
| dataA | input | 16 | Signed input sample, channel A |
| dataB | input | 16 | Signed input sample, channel B (dual mode only) |
| coefWe | input | 1 | Coefficient write strobe |
| coefNet | input | 1 | Coefficient bank select |
| coefAddr | input | 6 | Tap address within the bank |
| coefData | input | 16 | Signed coefficient value |
| resultA | output | 32 | Filter result, channel A or the combined filter |
| resultB | output | 32 | Filter result, channel B or the combined filter |
| outValid | output | 1 | One-cycle strobe marking a new result |

## Verification
On every cycle the assertions check these properties. A valid strobe is always preceded by the last multiply clock of a period. The sample shift never fires on two adjacent edges when the ratio is above one. The multiply phase stays below the ratio. The captured ratio and mode stay frozen during a run. A clear leaves both outputs at zero. The tail hand-on register changes only at a period end or a clear. Only the bench scenarios show that the results are numerically the right convolutions. They also show that the banks and the delayed taps are combined in the right order, that wrap-around matches 32-bit arithmetic, that the first result arrives at exactly the stated edge, and that disturbing the mode inputs during a run leaves the results unchanged.

// File: rtl/msfirPkg.sv
package msfirPkg;
  localparam int PH_W = 3;  // log2 of the largest clock-to-sample ratio

  typedef struct packed {
    logic            clear;
    logic            shift;
    logic            mac;
    logic            first;
    logic            last;
    logic [PH_W-1:0] phase;
  } strobeT;
endpackage

// File: rtl/msfirCtrl.sv
module msfirCtrl
  import msfirPkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         fen,
  input  logic [1:0]   ratioSel,
  input  logic         dualSel,
  output strobeT       stb,
  output logic [1:0]   ratioLog,
  output logic         dualOn,
  output logic         outValid
);
  localparam int CNT_W = $clog2(2 * STAGES) + 1;

  logic            fenQ, run, macOn, fenRise, take;
  logic [PH_W-1:0] phase, macPh, lastPh;
  logic [CNT_W-1:0] sampCnt, latency;

  assign lastPh  = PH_W'((1 << ratioLog) - 1);
  assign fenRise = fen & ~fenQ;
  assign take    = fen & (fenRise | (run & (phase == '0)));
  assign latency = dualOn ? CNT_W'(STAGES - 1) : CNT_W'(2 * STAGES - 1);

  always_comb begin
    stb.clear = clr;
    stb.shift = take & ~clr;
    stb.mac   = macOn & ~clr;
    stb.first = macOn & ~clr & (macPh == '0);
    stb.last  = macOn & ~clr & (macPh == lastPh);
    stb.phase = macPh;
  end

  // configuration is only taken while the filter is idle and disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioLog <= '0;
      dualOn   <= 1'b1;
    end else if (!run && !fen) begin
      ratioLog <= ratioSel;
      dualOn   <= dualSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fenQ     <= 1'b0;
      run      <= 1'b0;
      phase    <= '0;
      macOn    <= 1'b0;
      macPh    <= '0;
      sampCnt  <= '0;
      outValid <= 1'b0;
    end else if (clr) begin
      fenQ     <= fen;
      run      <= 1'b0;
      phase    <= '0;
      macOn    <= 1'b0;
      macPh    <= '0;
      sampCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      fenQ <= fen;
      run  <= fen & (run | fenRise);
      if (take)     phase <= (ratioLog == 2'd0) ? '0 : PH_W'(1);
      else if (run) phase <= (phase == lastPh) ? '0 : phase + 1'b1;
      if (take) begin
        macOn <= 1'b1;
        macPh <= '0;
      end else if (macOn) begin
        if (macPh == lastPh) macOn <= 1'b0;
        else                 macPh <= macPh + 1'b1;
      end
      if (stb.last && sampCnt <= latency) sampCnt <= sampCnt + 1'b1;
      outValid <= stb.last & (sampCnt >= latency);
    end
  end

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stb.last));  // R5
  AST_ONE_SHIFT_PER_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && ratioLog != 2'd0) |=> !stb.shift);  // R4
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    macOn |-> (macPh <= lastPh));  // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    run |=> ($stable(ratioLog) && $stable(dualOn)));  // R7
endmodule

// File: rtl/msfirDatapath.sv
module msfirDatapath
  import msfirPkg::*;
#(
  parameter int STAGES    = 8,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 32,
  parameter int MAX_RATIO = 8,
  parameter int ADDR_W    = $clog2(STAGES * MAX_RATIO)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   stb,
  input  logic [1:0]               ratioLog,
  input  logic                     dualOn,
  input  logic signed [DATA_W-1:0] dataA,
  input  logic signed [DATA_W-1:0] dataB,
  input  logic                     coefWe,
  input  logic                     coefNet,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic signed [ACC_W-1:0]  resultA,
  output logic signed [ACC_W-1:0]  resultB
);
  localparam int ALL_STAGES = 2 * STAGES;
  localparam int TAPS       = STAGES * MAX_RATIO;
  localparam int DEPTH      = ALL_STAGES * (MAX_RATIO + 1) - 1;
  localparam int IDX_W      = $clog2(DEPTH);

  logic signed [DATA_W-1:0] lineA [DEPTH];
  logic signed [DATA_W-1:0] lineB [DEPTH];
  logic signed [COEF_W-1:0] coefMem [2][TAPS];
  logic signed [ACC_W-1:0]  handOn [ALL_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        lineA[i] <= '0;
        lineB[i] <= '0;
      end
    end else if (stb.clear) begin
      for (int i = 0; i < DEPTH; i++) begin
        lineA[i] <= '0;
        lineB[i] <= '0;
      end
    end else if (stb.shift) begin
      lineA[0] <= dataA;
      lineB[0] <= dataB;
      for (int i = 1; i < DEPTH; i++) begin
        lineA[i] <= lineA[i-1];
        lineB[i] <= lineB[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (coefWe) coefMem[coefNet][coefAddr] <= coefData;
  end

  for (genvar g = 0; g < ALL_STAGES; g++) begin : gStage
    localparam int NET = g / STAGES;
    localparam int J   = g % STAGES;

    logic [IDX_W-1:0]         dIdx;
    logic [ADDR_W-1:0]        cIdx;
    logic signed [ACC_W-1:0]  xExt, cExt, prod, pIn, accNext, accR, handR;

    if (g == 0) begin : gHead
      assign pIn = '0;
    end else if (g == STAGES) begin : gJoin
      assign pIn = dualOn ? '0 : handOn[g-1];
    end else begin : gLink
      assign pIn = handOn[g-1];
    end

    always_comb begin
      cIdx = (ADDR_W'(J) << ratioLog) + ADDR_W'(stb.phase);
      if (NET == 1 && dualOn) begin
        dIdx = IDX_W'(J) + (IDX_W'(J) << ratioLog) + IDX_W'(stb.phase);
        xExt = ACC_W'(lineB[dIdx]);
      end else begin
        dIdx = IDX_W'(g) + (IDX_W'(g) << ratioLog) + IDX_W'(stb.phase);
        xExt = ACC_W'(lineA[dIdx]);
      end
      cExt    = ACC_W'(coefMem[NET][cIdx]);
      prod    = xExt * cExt;
      accNext = (stb.first ? pIn : accR) + prod;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accR  <= '0;
        handR <= '0;
      end else if (stb.clear) begin
        accR  <= '0;
        handR <= '0;
      end else begin
        if (stb.mac)  accR  <= accNext;
        if (stb.last) handR <= accNext;
      end
    end

    assign handOn[g] = handR;
  end

  assign resultA = dualOn ? handOn[STAGES-1] : handOn[ALL_STAGES-1];
  assign resultB = handOn[ALL_STAGES-1];

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (resultA == '0 && resultB == '0));  // R8
  AST_HANDON_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && !stb.last) |=> $stable(handOn[ALL_STAGES-1]));  // R5
endmodule

// File: rtl/msfirArray.sv
module msfirArray
  import msfirPkg::*;
#(
  parameter int STAGES    = 8,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 32,
  parameter int MAX_RATIO = 8,
  parameter int ADDR_W    = $clog2(STAGES * MAX_RATIO)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clr,
  input  logic                     fen,
  input  logic [1:0]               ratioSel,
  input  logic                     dualSel,
  input  logic signed [DATA_W-1:0] dataA,
  input  logic signed [DATA_W-1:0] dataB,
  input  logic                     coefWe,
  input  logic                     coefNet,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic signed [ACC_W-1:0]  resultA,
  output logic signed [ACC_W-1:0]  resultB,
  output logic                     outValid
);
  strobeT     stb;
  logic [1:0] ratioLog;
  logic       dualOn;

  msfirCtrl #(.STAGES(STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .clr(clr), .fen(fen),
    .ratioSel(ratioSel), .dualSel(dualSel),
    .stb(stb), .ratioLog(ratioLog), .dualOn(dualOn), .outValid(outValid)
  );

  msfirDatapath #(
    .STAGES(STAGES), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
    .MAX_RATIO(MAX_RATIO), .ADDR_W(ADDR_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .ratioLog(ratioLog), .dualOn(dualOn),
    .dataA(dataA), .dataB(dataB),
    .coefWe(coefWe), .coefNet(coefNet), .coefAddr(coefAddr), .coefData(coefData),
    .resultA(resultA), .resultB(resultB)
  );
endmodule

// File: tb/msfirArray_test.sv
module msfirArray_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clr = 1'b0, fen = 1'b0, dualSel = 1'b1;
  logic [1:0]  ratioSel = 2'd0;
  logic signed [15:0] dataA = '0, dataB = '0, coefData = '0;
  logic        coefWe = 1'b0, coefNet = 1'b0;
  logic [5:0]  coefAddr = '0;
  logic signed [31:0] resultA, resultB;
  logic        outValid;

  int nChk = 0, nFail = 0, cyc = 0, p0 = 0;
  int cA [64];
  int cB [64];
  int xa [200];
  int xb [200];
  int qA [$];
  int qB [$];
  bit benchDual = 1'b1, firstSeen = 1'b0;
  int benchL = 7, benchR = 1;
  string curReq = "R1";

  msfirArray uut (
    .clk(clk), .rstN(rstN), .clr(clr), .fen(fen), .ratioSel(ratioSel),
    .dualSel(dualSel), .dataA(dataA), .dataB(dataB), .coefWe(coefWe),
    .coefNet(coefNet), .coefAddr(coefAddr), .coefData(coefData),
    .resultA(resultA), .resultB(resultB), .outValid(outValid)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9: write both coefficient banks through the write port
  task automatic loadCoefs(input int mode);
    for (int net = 0; net < 2; net++) begin
      for (int k = 0; k < 64; k++) begin
        int v;
        if (mode == 0) v = ((k * 37 + net * 11) % 41) - 20 + net * 3;
        else           v = (k % 2 == 0) ? -32768 : 32767;
        if (net == 0) cA[k] = v; else cB[k] = v;
        @(negedge clk);
        coefWe = 1'b1; coefNet = net[0]; coefAddr = k[5:0]; coefData = v[15:0];
      end
    end
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  // driver: feeds samples and pushes expected results into the scoreboard
  task automatic runScenario(input int rlog, input bit dual, input int nSamp,
                             input int dataMode, input bit disturb, input string req);
    int r, lat;
    r = 1 << rlog;
    lat = dual ? 7 : 15;
    @(negedge clk);
    fen = 1'b0; ratioSel = rlog[1:0]; dualSel = dual; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(resultA == 0 && resultB == 0 && !outValid, "R8 clear", int'(resultA), 0);
    @(negedge clk);
    curReq = req; benchDual = dual; benchL = lat; benchR = r; firstSeen = 1'b0;
    qA.delete(); qB.delete();
    for (int n = 0; n < nSamp; n++) begin
      int yA, yB, taps;
      if (dataMode == 0) begin
        xa[n] = ((n * 73 + 11) % 201) - 100;
        xb[n] = ((n * 29) % 97) * 300 - 14000;
      end else begin
        xa[n] = (n % 3 == 0) ? 32767 : -32768;
        xb[n] = -32768;
      end
      taps = dual ? 8 * r : 16 * r;
      yA = 0; yB = 0;
      for (int k = 0; k < taps && k <= n; k++) begin
        int cf;
        cf = (k < 8 * r) ? cA[k] : cB[k - 8 * r];
        yA += cf * xa[n - k];
        if (dual) yB += cB[k] * xb[n - k];
      end
      qA.push_back(yA);
      if (dual) qB.push_back(yB);
      @(negedge clk);
      dataA = xa[n][15:0]; dataB = xb[n][15:0]; fen = 1'b1;
      if (n == 0) p0 = cyc + 1;
      if (disturb && n == lat + 3) begin  // R7: mode inputs move during the run
        ratioSel = ~rlog[1:0]; dualSel = ~dual;
      end
      repeat (r - 1) @(negedge clk);
    end
    @(negedge clk);
    fen = 1'b0; dataA = '0; dataB = '0; ratioSel = rlog[1:0]; dualSel = dual;
    repeat (r + 4) @(negedge clk);
    check(qA.size() == lat, "R5 result count", qA.size(), lat);
  endtask

  // monitor: compares each strobed result against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (!firstSeen) begin
        firstSeen = 1'b1;
        check(cyc - p0 == (benchL + 1) * benchR, "R5 first result edge",
              cyc - p0, (benchL + 1) * benchR);
      end
      if (qA.size() == 0) begin
        check(1'b0, "R5 unexpected result", int'(resultA), 0);
      end else begin
        int e;
        e = qA.pop_front();
        check(resultA == e, curReq, int'(resultA), e);
        if (benchDual) begin
          if (qB.size() == 0) check(1'b0, "R2 unexpected B", int'(resultB), 0);
          else begin
            int eb;
            eb = qB.pop_front();
            check(resultB == eb, curReq, int'(resultB), eb);
          end
        end else begin
          check(resultB == e, "R3 combined on B", int'(resultB), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resultA == 0 && resultB == 0 && !outValid, "R1 reset", int'(resultA), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(resultA == 0 && resultB == 0 && !outValid, "R1 after release", int'(resultB), 0);
    loadCoefs(0);
    runScenario(0, 1'b1, 30, 0, 1'b0, "R2");
    runScenario(2, 1'b1, 50, 0, 1'b0, "R4");
    runScenario(1, 1'b0, 50, 0, 1'b0, "R3");
    loadCoefs(1);
    runScenario(3, 1'b0, 150, 1, 1'b0, "R6");
    loadCoefs(0);
    runScenario(3, 1'b1, 40, 0, 1'b1, "R7");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule